// File: doc/BRIEF.md
# Dual Auto-Reload Timer with Forced Overflow

This block holds two independent 12-bit up-counters that advance together on a shared clock-enable pulse (`tick_en`). Each counter restarts from its own reload value after passing the all-ones value. Each one drives a PWM output whose duty is set by a compare value. Software writes the compare value into a shadow copy. The active copy takes the new value only when an overflow happens, so a period never gets a torn duty cycle. A per-counter force bit jumps the counter to the all-ones value. The next count pulse then overflows, reloads and applies the new compare value at once, without waiting for the count to wrap.

A capture input is synchronised through two flops. Its rising edge latches the value of counter 1 and raises a capture flag. Three event flags (one overflow per counter, plus capture) stay set until software clears them. Each flag drives an interrupt line through its own enable, and all three lines are gated by a global mask input. A halt input freezes both counters. Software reaches everything through a plain synchronous register port: a single-cycle write strobe and a combinational read.

Each counter is controlled by a two-state machine. `CS_RUN` is normal counting. `CS_ARMED` means a forced overflow is pending, and the force bit reads as 1 in this state. The transition `RUN->ARMED` fires on a force write. The transition `ARMED->RUN` fires on the overflow that the next unhalted count pulse produces. A force write in `CS_ARMED` keeps the state as it is.

Register addresses (4-bit): 0 CTRL (bit0 overflow-1 enable, bit1 overflow-2 enable, bit2 capture enable), 1 STATUS (bit0 overflow-1, bit1 overflow-2, bit2 capture, write 1 to clear), 2 FORCE (bit0 counter 1, bit1 counter 2, write 1 to set), 3 RELOAD1, 4 RELOAD2, 5 DUTY1 shadow, 6 DUTY2 shadow, 7 CAPTURE (read-only), 8 COUNT1 (read-only), 9 COUNT2 (read-only), 10 active DUTY1 (read-only), 11 active DUTY2 (read-only). Unmapped addresses read 0.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset, both counters, all flags, enables and force bits, and all reload and duty registers read 0, and the PWM and interrupt outputs are low.
- R2: On each cycle with `tick_en`=1 and `halt_i`=0, each counter below FFFh increments by 1. With `tick_en`=0 the counters hold.
- R3: A count pulse that finds a counter at FFFh loads it with its reload register and sets its overflow flag (STATUS bit0 for counter 1, bit1 for counter 2).
- R4: Writing 1 to a FORCE bit (bit0 counter 1, bit1 counter 2) makes that counter read FFFh and the bit read 1 from the next cycle. The next unhalted count pulse overflows that counter, and the bit then reads 0. The other counter is not affected.
- R5: Writes to DUTY1/DUTY2 reach only the shadow copy. The active compare value takes the shadow value only at that counter's overflow, whether the overflow is natural or forced.
- R6: Each PWM output is high while its counter is below its active compare value, and low otherwise.
- R7: A STATUS flag is cleared by writing 1 to its bit, and writing 0 leaves it set. When an event and a clear of the same flag fall in the same cycle, the flag stays set.
- R8: Each interrupt output equals its flag AND its CTRL enable AND NOT `irq_mask_i`.
- R9: While `halt_i`=1, both counters hold their values, and a force bit that has been set stays pending.
- R10: A rising edge of `cap_i`, seen after a two-flop synchroniser, copies counter 1 into CAPTURE and sets STATUS bit2. A steady or falling `cap_i` captures nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Shared count enable pulse |
| halt_i | input | 1 | Freeze both counters |
| irq_mask_i | input | 1 | Global interrupt mask, 1 blocks all interrupts |
| cap_i | input | 1 | Asynchronous capture input |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 12 | Register write data |
| reg_rdata | output | 12 | Register read data (combinational) |
| pwm1_o | output | 1 | PWM output of counter 1 |
| pwm2_o | output | 1 | PWM output of counter 2 |
| irq_ovf1_o | output | 1 | Counter 1 overflow interrupt |
| irq_ovf2_o | output | 1 | Counter 2 overflow interrupt |
| irq_cap_o | output | 1 | Capture interrupt |

## Verification
The bench forces counter 1 while counter 2 keeps counting. A design that shared the force logic would disturb counter 2 or leave the force bit stuck. It writes a new duty value and checks that the active compare value holds until the forced overflow. A design without the shadow copy would change the PWM in the middle of a period. It issues a flag clear in the same cycle as an overflow, which exposes a design where the clear wins. It also forces a counter while `halt_i` is high: a design that overflowed anyway, or dropped the pending force, shows a wrong count or a wrong FORCE readback. Finally it holds `cap_i` at a steady level after the capture edge, which catches a level-sensitive capture that would keep re-setting the flag.

// File: rtl/arl_pkg.sv
package arl_pkg;
    localparam int CNT_W  = 12;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 4'd0,
        A_STATUS = 4'd1,
        A_FORCE  = 4'd2,
        A_RLD1   = 4'd3,
        A_RLD2   = 4'd4,
        A_DUTY1  = 4'd5,
        A_DUTY2  = 4'd6,
        A_CAPT   = 4'd7,
        A_CNT1   = 4'd8,
        A_CNT2   = 4'd9,
        A_ACT1   = 4'd10,
        A_ACT2   = 4'd11
    } reg_addr_e;

    typedef enum logic {
        CS_RUN   = 1'b0,
        CS_ARMED = 1'b1
    } cnt_state_e;
endpackage

// File: rtl/arl_counter.sv
module arl_counter
    import arl_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         force_wr,
    input  logic [W-1:0] reload,
    input  logic [W-1:0] duty_shadow,
    output logic [W-1:0] cnt,
    output logic [W-1:0] duty_act,
    output logic         armed,
    output logic         ovf_evt,
    output logic         pwm
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    cnt_state_e state_q, state_d;
    logic [W-1:0] cnt_q, duty_q;

    assign ovf_evt = step && !force_wr && (cnt_q == TOP);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_RUN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_RUN:   if (force_wr) state_d = CS_ARMED;
            CS_ARMED: if (ovf_evt)  state_d = CS_RUN;
            default:  state_d = CS_RUN;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            duty_q <= '0;
        end else begin
            if (force_wr)     cnt_q <= TOP;
            else if (ovf_evt) cnt_q <= reload;
            else if (step)    cnt_q <= cnt_q + 1'b1;
            if (ovf_evt)      duty_q <= duty_shadow;
        end
    end

    // outputs
    always_comb begin
        cnt      = cnt_q;
        duty_act = duty_q;
        armed    = (state_q == CS_ARMED);
        pwm      = (cnt_q < duty_q);
    end

    p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !force_wr && cnt_q != TOP) |=> cnt_q == $past(cnt_q) + 1'b1);
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !force_wr && cnt_q == TOP) |=> cnt_q == $past(reload));
    p_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
        force_wr |=> (cnt_q == TOP && state_q == CS_ARMED));
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !force_wr) |=> $stable(cnt_q));
    p_shadow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_evt |=> $stable(duty_q));
endmodule

// File: rtl/arl_capture.sv
module arl_capture #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_i,
    input  logic [W-1:0] cnt1,
    output logic [W-1:0] capt,
    output logic         cap_evt
);
    logic s1_q, s2_q, s3_q;
    logic [W-1:0] capt_q;

    assign cap_evt = s2_q && !s3_q;
    assign capt    = capt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            s3_q   <= 1'b0;
            capt_q <= '0;
        end else begin
            s1_q <= cap_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
            if (cap_evt) capt_q <= cnt1;
        end
    end

    p_capt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> capt_q == $past(cnt1));
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
    import arl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              halt_i,
    input  logic              irq_mask_i,
    input  logic              cap_i,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              pwm1_o,
    output logic              pwm2_o,
    output logic              irq_ovf1_o,
    output logic              irq_ovf2_o,
    output logic              irq_cap_o
);
    localparam int NCNT  = 2;
    localparam int NFLAG = NCNT + 1;
    localparam int PAD   = CNT_W - NFLAG;

    logic [CNT_W-1:0] rld_q  [NCNT];
    logic [CNT_W-1:0] duty_q [NCNT];
    logic [CNT_W-1:0] cnt    [NCNT];
    logic [CNT_W-1:0] act    [NCNT];
    logic [NCNT-1:0]  armed, ovf_evt, pwm, force_wr;
    logic [NFLAG-1:0] en_q, flag_q, evt, clr, irq;
    logic [CNT_W-1:0] capt;
    logic             cap_evt, step;

    assign step = tick_en && !halt_i;

    genvar g;
    generate
        for (g = 0; g < NCNT; g++) begin : g_cnt
            assign force_wr[g] = reg_wr && (reg_addr == A_FORCE) && reg_wdata[g];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rld_q[g]  <= '0;
                    duty_q[g] <= '0;
                end else if (reg_wr) begin
                    if (reg_addr == ADDR_W'(A_RLD1 + g))  rld_q[g]  <= reg_wdata;
                    if (reg_addr == ADDR_W'(A_DUTY1 + g)) duty_q[g] <= reg_wdata;
                end
            end

            arl_counter #(.W(CNT_W)) u_cnt (
                .clk         (clk),
                .rst_n       (rst_n),
                .step        (step),
                .force_wr    (force_wr[g]),
                .reload      (rld_q[g]),
                .duty_shadow (duty_q[g]),
                .cnt         (cnt[g]),
                .duty_act    (act[g]),
                .armed       (armed[g]),
                .ovf_evt     (ovf_evt[g]),
                .pwm         (pwm[g])
            );
        end
    endgenerate

    arl_capture #(.W(CNT_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (cap_i),
        .cnt1    (cnt[0]),
        .capt    (capt),
        .cap_evt (cap_evt)
    );

    assign evt = {cap_evt, ovf_evt};
    assign clr = (reg_wr && reg_addr == A_STATUS) ? reg_wdata[NFLAG-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            en_q   <= '0;
        end else begin
            flag_q <= (flag_q & ~clr) | evt;
            if (reg_wr && reg_addr == A_CTRL) en_q <= reg_wdata[NFLAG-1:0];
        end
    end

    assign irq = flag_q & en_q & {NFLAG{!irq_mask_i}};

    always_comb begin
        pwm1_o     = pwm[0];
        pwm2_o     = pwm[1];
        irq_ovf1_o = irq[0];
        irq_ovf2_o = irq[1];
        irq_cap_o  = irq[2];
    end

    always_comb begin
        case (reg_addr)
            A_CTRL:   reg_rdata = {{PAD{1'b0}}, en_q};
            A_STATUS: reg_rdata = {{PAD{1'b0}}, flag_q};
            A_FORCE:  reg_rdata = {{(CNT_W-NCNT){1'b0}}, armed};
            A_RLD1:   reg_rdata = rld_q[0];
            A_RLD2:   reg_rdata = rld_q[1];
            A_DUTY1:  reg_rdata = duty_q[0];
            A_DUTY2:  reg_rdata = duty_q[1];
            A_CAPT:   reg_rdata = capt;
            A_CNT1:   reg_rdata = cnt[0];
            A_CNT2:   reg_rdata = cnt[1];
            A_ACT1:   reg_rdata = act[0];
            A_ACT2:   reg_rdata = act[1];
            default:  reg_rdata = '0;
        endcase
    end

    p_setwins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt[0] |=> flag_q[0]);
    p_capflag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> flag_q[2]);
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ovf1_o || irq_ovf2_o || irq_cap_o) |-> !irq_mask_i);
    p_force_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt[0] && !force_wr[0]) |=> !armed[0]);
endmodule

// File: tb/dual_reload_timer_tb.sv
module dual_reload_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0, halt_i = 1'b0, irq_mask_i = 1'b0, cap_i = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [11:0] reg_wdata = '0;
    logic [11:0] reg_rdata;
    logic        pwm1_o, pwm2_o, irq_ovf1_o, irq_ovf2_o, irq_cap_o;

    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    dual_reload_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .halt_i(halt_i),
        .irq_mask_i(irq_mask_i), .cap_i(cap_i), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pwm1_o(pwm1_o), .pwm2_o(pwm2_o), .irq_ovf1_o(irq_ovf1_o),
        .irq_ovf2_o(irq_ovf2_o), .irq_cap_o(irq_cap_o)
    );

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [11:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [11:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [11:0] d;
        for (int a = 0; a < 12; a++) begin
            rd(a[3:0], d);
            check("R1 reset reg", d, 12'h000);
        end
        check("R1 pwm/irq", {7'd0, pwm1_o, pwm2_o, irq_ovf1_o, irq_ovf2_o, irq_cap_o}, 12'h000);
    endtask

    task automatic t_count;
        logic [11:0] d;
        tick(5);
        rd(8, d); check("R2 cnt1", d, 12'h005);
        rd(9, d); check("R2 cnt2", d, 12'h005);
        repeat (3) @(negedge clk);
        rd(8, d); check("R2 hold without tick", d, 12'h005);
    endtask

    task automatic t_force;
        logic [11:0] d;
        wr(3, 12'hFF0);
        wr(5, 12'hFF8);
        wr(2, 12'h001);
        rd(8, d); check("R4 forced cnt1", d, 12'hFFF);
        rd(2, d); check("R4 force bit set", d, 12'h001);
        rd(9, d); check("R4 cnt2 untouched", d, 12'h005);
        rd(10, d); check("R5 active before ovf", d, 12'h000);
        tick(1);
        rd(8, d); check("R4 reload after force", d, 12'hFF0);
        rd(2, d); check("R4 force bit cleared", d, 12'h000);
        rd(1, d); check("R4 ovf1 flag only", d, 12'h001);
        rd(9, d); check("R4 cnt2 counts on", d, 12'h006);
        rd(10, d); check("R5 active after forced ovf", d, 12'hFF8);
        check("R6 pwm high below compare", {11'd0, pwm1_o}, 12'h001);
    endtask

    task automatic t_wrap;
        logic [11:0] d;
        tick(8);
        check("R6 pwm low at compare", {11'd0, pwm1_o}, 12'h000);
        wr(1, 12'h001);
        rd(1, d); check("R7 w1c clears", d, 12'h000);
        tick(7);
        rd(8, d); check("R2 reach top", d, 12'hFFF);
        rd(1, d); check("R3 no flag before wrap", d, 12'h000);
        tick(1);
        rd(8, d); check("R3 natural reload", d, 12'hFF0);
        rd(1, d); check("R3 natural ovf flag", d, 12'h001);
    endtask

    task automatic t_shadow;
        logic [11:0] d;
        wr(5, 12'h100);
        rd(5, d);  check("R5 shadow written", d, 12'h100);
        rd(10, d); check("R5 active unchanged", d, 12'hFF8);
        check("R6 pwm follows active", {11'd0, pwm1_o}, 12'h001);
        wr(2, 12'h001);
        tick(1);
        rd(10, d); check("R5 active updated", d, 12'h100);
        check("R6 pwm low above compare", {11'd0, pwm1_o}, 12'h000);
    endtask

    task automatic t_flags;
        logic [11:0] d;
        wr(1, 12'h000);
        rd(1, d); check("R7 write 0 keeps", d, 12'h001);
        wr(1, 12'h001);
        rd(1, d); check("R7 write 1 clears", d, 12'h000);
        wr(2, 12'h001);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd1; reg_wdata = 12'h001; tick_en = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tick_en = 1'b0;
        rd(1, d); check("R7 set wins over clear", d, 12'h001);
    endtask

    task automatic t_irq;
        wr(0, 12'h001);
        irq_mask_i = 1'b0; #1;
        check("R8 irq enabled", {11'd0, irq_ovf1_o}, 12'h001);
        check("R8 irq2 no flag", {11'd0, irq_ovf2_o}, 12'h000);
        irq_mask_i = 1'b1; #1;
        check("R8 irq masked", {11'd0, irq_ovf1_o}, 12'h000);
        irq_mask_i = 1'b0;
        wr(0, 12'h000);
        check("R8 irq disabled", {11'd0, irq_ovf1_o}, 12'h000);
    endtask

    task automatic t_halt;
        logic [11:0] c1, c2, d;
        rd(8, c1); rd(9, c2);
        halt_i = 1'b1;
        tick(5);
        rd(8, d); check("R9 cnt1 frozen", d, c1);
        rd(9, d); check("R9 cnt2 frozen", d, c2);
        wr(4, 12'h000);
        wr(2, 12'h002);
        tick(3);
        rd(9, d); check("R9 forced cnt2 held", d, 12'hFFF);
        rd(2, d); check("R9 force pending", d, 12'h002);
        rd(1, d); check("R9 no ovf2 while halted", d, 12'h001);
        halt_i = 1'b0;
        tick(1);
        rd(9, d); check("R4 cnt2 reload", d, 12'h000);
        rd(2, d); check("R4 force2 cleared", d, 12'h000);
        rd(1, d); check("R3 ovf2 flag", d, 12'h003);
        wr(1, 12'h003);
    endtask

    task automatic t_capture;
        logic [11:0] c1, d;
        wr(0, 12'h004);
        rd(8, c1);
        @(negedge clk); cap_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd(7, d); check("R10 captured cnt1", d, c1);
        rd(1, d); check("R10 icf set", d, 12'h004);
        check("R8 irq_cap", {11'd0, irq_cap_o}, 12'h001);
        wr(1, 12'h004);
        tick(2);
        repeat (4) @(negedge clk);
        rd(1, d); check("R10 steady high no capture", d, 12'h000);
        rd(7, d); check("R10 capture reg held", d, c1);
        cap_i = 1'b0;
        repeat (4) @(negedge clk);
        rd(1, d); check("R10 falling edge no capture", d, 12'h000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_force();
        t_wrap();
        t_shadow();
        t_flags();
        t_irq();
        t_halt();
        t_capture();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule